// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block decides the operating mode of a CAN protocol controller. Software asks for halt or sleep through two request levels. The protocol engine reports when the bus is idle or in the intermission field. It also supplies the sampled receive bit and a strobe that marks each bit time. From these inputs the sequencer drives four outputs: the enable for bus participation, the clock enable for the core protocol logic, a halt-complete status flag, and a permit for register accesses.

The states are RUN, QUIESCE, HALTED, REJOIN and SLEEP. The transitions are:

- **RUN→QUIESCE**: a halt or sleep request arrives.
- **QUIESCE→RUN**: the request is withdrawn.
- **QUIESCE→HALTED** or **QUIESCE→SLEEP**: the bus is quiet, and sleep takes priority.
- **HALTED→SLEEP**: a sleep request arrives.
- **HALTED→REJOIN**: the halt request is released.
- **SLEEP→HALTED** or **SLEEP→REJOIN**: sleep is released, and the choice depends on whether halt is still requested.
- **REJOIN→SLEEP** or **REJOIN→HALTED**: a new request arrives.
- **REJOIN→RUN**: eleven consecutive recessive bits have been seen.

Software polls the halt flag before it rewrites configuration. While asleep, only four control and status registers remain reachable. The transmit-acknowledge, abort-acknowledge, receive-pending and remote-frame-pending flags live in gated registers, so software must clear them before it asks for sleep.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the block is in RUN: `bus_en`=1, `core_clk_en`=1, `halted`=0, `acc_refused`=0, and every register access is permitted.
- R2: A halt request in RUN moves the block to QUIESCE. In QUIESCE it keeps `bus_en`=1 until a cycle in which `bus_idle` or `bus_ifs` is high. The block is HALTED after that cycle's clock edge.
- R3: In HALTED, `halted`=1 and `bus_en`=0. `halted` rises in the cycle after the entry edge.
- R4: A request withdrawn during QUIESCE returns the block to RUN, and `halted` never rises.
- R5: Releasing halt enters REJOIN with `bus_en`=0. The block returns to RUN on the edge after the 11th consecutive recessive sample (`rx_bit`=1 with `bit_tick`=1).
- R6: A dominant sample (`rx_bit`=0 with `bit_tick`=1) restarts the recessive count at zero. Cycles without `bit_tick` do not count.
- R7: In SLEEP, `core_clk_en`=0 and `bus_en`=0. Sleep is entered through QUIESCE from RUN, or directly from HALTED.
- R8: In SLEEP, only register indices 0, 1, 2 and 3 are permitted, and `acc_permit` is 0 for any other index. Each cycle with `acc_valid`=1 and a refused index raises `acc_refused` for exactly the following cycle. Outside SLEEP, all indices are permitted.
- R9: Releasing sleep restores `core_clk_en` on the next edge. The block then goes through REJOIN, or to HALTED if halt is still requested.
- R10: When both requests are present in QUIESCE and the bus is quiet, SLEEP wins over HALTED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | Halt request level from software |
| sleep_req | input | 1 | Sleep request level from software |
| bus_idle | input | 1 | Protocol engine reports bus idle |
| bus_ifs | input | 1 | Protocol engine reports intermission field |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| rx_bit | input | 1 | Sampled receive bit, 1 = recessive |
| acc_valid | input | 1 | Register access attempted this cycle |
| acc_index | input | IDX_W | Index of the register accessed |
| bus_en | output | 1 | Controller may take part in bus traffic |
| core_clk_en | output | 1 | Clock enable for the core protocol logic |
| halted | output | 1 | Halt-complete status flag |
| acc_permit | output | 1 | Access at `acc_index` is allowed (combinational) |
| acc_refused | output | 1 | One-cycle pulse after a refused access |

## Verification
The mode outputs come straight from the state register, so `bus_en`, `core_clk_en` and `halted` change exactly one edge after the input that triggers the transition. REJOIN→RUN is one edge later than the 11th recessive strobe, because the counter registers its saturation first. `acc_permit` is combinational and is read in the same cycle as the index it answers. `acc_refused` is registered and is read after the next edge. The bench drives inputs one time unit after a rising edge and samples after a further unit, so each check lands in the cycle its result is due.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
    typedef enum logic [2:0] {
        MODE_RUN,
        MODE_QUIESCE,
        MODE_HALTED,
        MODE_REJOIN,
        MODE_SLEEP
    } mode_e;
endpackage

// File: rtl/recessive_counter.sv
module recessive_counter #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bit_tick,
    input  logic rx_bit,
    output logic done
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (bit_tick) begin
            if (!rx_bit)
                cnt <= '0;
            else if (cnt != LIMIT)
                cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIMIT);

    // R6: a dominant sample restarts the run
    a_r6_dominant_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && bit_tick && !rx_bit) |=> (cnt == '0));
    // R5: the count never exceeds the run length
    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);
endmodule

// File: rtl/access_gate.sv
module access_gate #(
    parameter int IDX_W    = 5,
    parameter int NUM_OPEN = 4,
    parameter logic [NUM_OPEN*IDX_W-1:0] OPEN_IDX = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleeping,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_index,
    output logic             acc_permit,
    output logic             acc_refused
);
    logic [NUM_OPEN-1:0] hit;
    logic                refused_q;

    for (genvar g = 0; g < NUM_OPEN; g++) begin : g_open
        assign hit[g] = (acc_index == OPEN_IDX[g*IDX_W +: IDX_W]);
    end

    assign acc_permit = !sleeping || (|hit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            refused_q <= 1'b0;
        else
            refused_q <= acc_valid && !acc_permit;
    end

    assign acc_refused = refused_q;

    // R8: a refusal only follows an access made during sleep
    a_r8_refuse_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        acc_refused |-> $past(sleeping && acc_valid));
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import can_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic sleep_req,
    input  logic bus_quiet,
    input  logic rejoin_done,
    output logic bus_en,
    output logic core_clk_en,
    output logic halted,
    output logic sleeping,
    output logic cnt_clear
);
    mode_e mode, mode_nx;

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MODE_RUN:
                if (halt_req || sleep_req) mode_nx = MODE_QUIESCE;
            MODE_QUIESCE:
                if (!halt_req && !sleep_req) mode_nx = MODE_RUN;
                else if (bus_quiet)          mode_nx = sleep_req ? MODE_SLEEP : MODE_HALTED;
            MODE_HALTED:
                if (sleep_req)      mode_nx = MODE_SLEEP;
                else if (!halt_req) mode_nx = MODE_REJOIN;
            MODE_SLEEP:
                if (!sleep_req) mode_nx = halt_req ? MODE_HALTED : MODE_REJOIN;
            MODE_REJOIN:
                if (sleep_req)        mode_nx = MODE_SLEEP;
                else if (halt_req)    mode_nx = MODE_HALTED;
                else if (rejoin_done) mode_nx = MODE_RUN;
            default: mode_nx = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= MODE_RUN;
        else        mode <= mode_nx;
    end

    always_comb begin
        bus_en      = (mode == MODE_RUN) || (mode == MODE_QUIESCE);
        core_clk_en = (mode != MODE_SLEEP);
        halted      = (mode == MODE_HALTED);
        sleeping    = (mode == MODE_SLEEP);
        cnt_clear   = (mode != MODE_REJOIN);
    end

    // R2: halt is entered only from a quiet bus
    a_r2_quiet_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALTED && $past(mode) == MODE_QUIESCE) |-> $past(bus_quiet));
    // R5: rejoin completes only after the recessive run
    a_r5_rejoin_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && $past(mode) == MODE_REJOIN) |-> $past(rejoin_done));
    // R4: leaving the pending state for run needs both requests gone
    a_r4_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && $past(mode) == MODE_QUIESCE) |-> !$past(halt_req || sleep_req));
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq #(
    parameter int IDX_W    = 5,
    parameter int RUN_LEN  = 11,
    parameter int CTRL_IDX = 0,
    parameter int STAT_IDX = 1,
    parameter int IRQ_IDX  = 2,
    parameter int MASK_IDX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             sleep_req,
    input  logic             bus_idle,
    input  logic             bus_ifs,
    input  logic             bit_tick,
    input  logic             rx_bit,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_index,
    output logic             bus_en,
    output logic             core_clk_en,
    output logic             halted,
    output logic             acc_permit,
    output logic             acc_refused
);
    localparam logic [4*IDX_W-1:0] OPEN_LIST = {IDX_W'(MASK_IDX), IDX_W'(IRQ_IDX),
                                                IDX_W'(STAT_IDX), IDX_W'(CTRL_IDX)};

    logic sleeping, cnt_clear, rejoin_done;

    mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_req    (halt_req),
        .sleep_req   (sleep_req),
        .bus_quiet   (bus_idle || bus_ifs),
        .rejoin_done (rejoin_done),
        .bus_en      (bus_en),
        .core_clk_en (core_clk_en),
        .halted      (halted),
        .sleeping    (sleeping),
        .cnt_clear   (cnt_clear)
    );

    recessive_counter #(.RUN_LEN(RUN_LEN)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .bit_tick (bit_tick),
        .rx_bit   (rx_bit),
        .done     (rejoin_done)
    );

    access_gate #(.IDX_W(IDX_W), .NUM_OPEN(4), .OPEN_IDX(OPEN_LIST)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleeping    (sleeping),
        .acc_valid   (acc_valid),
        .acc_index   (acc_index),
        .acc_permit  (acc_permit),
        .acc_refused (acc_refused)
    );

    // R7: with the core clock stopped the controller stays off the bus
    a_r7_gated_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> !bus_en);
endmodule

// File: tb/test_can_mode_seq.sv
module test_can_mode_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 0, sleep_req = 0, bus_idle = 0, bus_ifs = 0;
    logic bit_tick = 0, rx_bit = 1, acc_valid = 0;
    logic [4:0] acc_index = '0;
    logic bus_en, core_clk_en, halted, acc_permit, acc_refused;
    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    can_mode_seq i_can_mode_seq (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_req(sleep_req),
        .bus_idle(bus_idle), .bus_ifs(bus_ifs), .bit_tick(bit_tick), .rx_bit(rx_bit),
        .acc_valid(acc_valid), .acc_index(acc_index), .bus_en(bus_en),
        .core_clk_en(core_clk_en), .halted(halted), .acc_permit(acc_permit),
        .acc_refused(acc_refused)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic strobe(input logic bitv);
        bit_tick = 1; rx_bit = bitv; step();
        bit_tick = 0; rx_bit = 1; step();
    endtask

    task automatic t_reset();
        chk("R1", "bus_en", bus_en, 1);
        chk("R1", "core_clk_en", core_clk_en, 1);
        chk("R1", "halted", halted, 0);
        chk("R1", "acc_refused", acc_refused, 0);
        acc_index = 5'd17; #1;
        chk("R1", "acc_permit", acc_permit, 1);
    endtask

    task automatic t_halt_pending();
        halt_req = 1; step();
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R2", "bus_en while pending", bus_en, 1);
            chk("R2", "halted while pending", halted, 0);
        end
        bus_ifs = 1; step(); bus_ifs = 0;
        chk("R3", "halted", halted, 1);
        chk("R3", "bus_en", bus_en, 0);
    endtask

    task automatic t_rejoin();
        halt_req = 0; step();
        chk("R5", "bus_en in rejoin", bus_en, 0);
        chk("R5", "halted cleared", halted, 0);
        for (int i = 0; i < 5; i++) strobe(1);
        strobe(0);
        for (int i = 0; i < 4; i++) step();
        for (int i = 0; i < 10; i++) strobe(1);
        chk("R6", "bus_en after dominant restart", bus_en, 0);
        bit_tick = 1; rx_bit = 1; step(); bit_tick = 0;
        chk("R5", "bus_en on 11th edge", bus_en, 0);
        step();
        chk("R5", "bus_en after rejoin", bus_en, 1);
    endtask

    task automatic t_withdraw();
        halt_req = 1; step(); step();
        chk("R4", "bus_en pending", bus_en, 1);
        halt_req = 0; step();
        chk("R4", "halted", halted, 0);
        bus_idle = 1; step(); step(); bus_idle = 0;
        chk("R4", "bus_en back in run", bus_en, 1);
        chk("R4", "halted stays low", halted, 0);
    endtask

    task automatic t_sleep();
        sleep_req = 1; bus_idle = 1; step();
        chk("R7", "core_clk_en pending", core_clk_en, 1);
        step(); bus_idle = 0;
        chk("R7", "core_clk_en", core_clk_en, 0);
        chk("R7", "bus_en", bus_en, 0);
        acc_valid = 1; acc_index = 5'd2; #1;
        chk("R8", "permit idx2", acc_permit, 1);
        acc_index = 5'd0; #1;
        chk("R8", "permit idx0", acc_permit, 1);
        step();
        chk("R8", "no refusal idx0", acc_refused, 0);
        acc_index = 5'd9; #1;
        chk("R8", "permit idx9", acc_permit, 0);
        step(); acc_valid = 0;
        chk("R8", "refusal pulse", acc_refused, 1);
        step();
        chk("R8", "pulse one cycle", acc_refused, 0);
    endtask

    task automatic t_sleep_exit();
        sleep_req = 0; step();
        chk("R9", "core_clk_en restored", core_clk_en, 1);
        chk("R9", "bus_en still off", bus_en, 0);
        acc_valid = 1; acc_index = 5'd9; #1;
        chk("R8", "permit outside sleep", acc_permit, 1);
        step(); acc_valid = 0;
        chk("R8", "no refusal outside sleep", acc_refused, 0);
        for (int i = 0; i < 11; i++) strobe(1);
        chk("R9", "bus_en after rejoin", bus_en, 1);
    endtask

    task automatic t_priority_and_halt_exit();
        halt_req = 1; sleep_req = 1; step();
        bus_idle = 1; step(); bus_idle = 0;
        chk("R10", "sleep wins", core_clk_en, 0);
        chk("R10", "not halted", halted, 0);
        sleep_req = 0; step();
        chk("R9", "halt held after sleep", halted, 1);
        chk("R9", "core_clk_en", core_clk_en, 1);
        sleep_req = 1; step();
        chk("R7", "halted to sleep", core_clk_en, 0);
        sleep_req = 0; halt_req = 0; step();
        for (int i = 0; i < 11; i++) strobe(1);
        chk("R5", "final run", bus_en, 1);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1;
        chk("R1", "bus_en in reset", bus_en, 1);
        step(); step();
        rst_n = 1;
        step();
        t_reset();
        t_halt_pending();
        t_rejoin();
        t_withdraw();
        t_sleep();
        t_sleep_exit();
        t_priority_and_halt_exit();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule